// File: doc/BRIEF.md
# Programmable Asynchronous SRAM Access Sequencer

This block turns single host read and write requests into timed bus cycles for an external asynchronous byte-wide SRAM. Each access runs a tick counter from zero up to a programmed total length. The read strobe, the write strobe and the chip select each go low inside their own window of that count. Every window is set by a setup count (the ticks before the line asserts) and a pulse count (the ticks it stays low). Reads and writes use separate window sets and separate total lengths. The total length is given in a 9-bit field with split encoding. All lines toward the SRAM come straight from flops.

The host presents one request at a time with valid/ready. It raises `host_valid` and holds the direction, address and write data steady. The block asserts `host_ready` for exactly one cycle, in the tick after the access ends, and the handshake completes on that edge. Back-pressure is implicit: a request that cannot start waits for as long as needed, and the host must not change it while it waits. On a read, `host_rdata` carries the captured byte during the ready cycle and holds it until the next read.

A configuration checker watches the timing inputs continuously. It raises `cfg_err` when a setting is illegal, and while `cfg_err` is high no access starts. After every read, a programmable number of idle ticks must pass before a write may drive the data bus again.

Top module: `sram_timing_ctrl`

## Requirements
- R1: After reset, `sram_cs_n`, `sram_oe_n` and `sram_we_n` are high, `sram_dq_oe` and `host_ready` are low, and `cfg_err` is low for a legal setting.
- R2: The total-length field f[8:0] decodes to f[8:7]*256 + f[6:0] ticks. A write drives `sram_dq_oe` high for exactly that many consecutive ticks. On a read, the gap from the first tick of chip select to the ready tick equals the decoded length minus the chip-select setup count.
- R3: If any of the four pulse counts is 0, `cfg_err` goes high. While it is high, no access starts: chip select stays high and `host_ready` stays low.
- R4: Each line goes low at tick `setup` of its access and stays low for exactly `pulse` ticks. The read strobe and read chip select use the read counts. The write strobe and write chip select use the write counts.
- R5: A setup count of 0 makes the line assert in the first tick of the access, the same tick in which a write starts driving the bus.
- R6: With `cfg_rd_by_strobe`=1, read data is sampled in the last tick the read strobe is low. With it at 0, read data is sampled in the last tick the chip select is low.
- R7: Address and write data stay driven through the tick after the controlling write line (the write strobe when `cfg_wr_by_strobe`=1, otherwise the chip select) rises. `cfg_err` is raised if that line's setup+pulse is not less than the write length, or if any line's setup+pulse exceeds its access length.
- R8: After a read, at least `cfg_float` ticks pass with chip select, read strobe and bus drive all inactive before `sram_dq_oe` rises again.
- R9: `host_ready` is high for exactly one cycle per access. A request held while blocked completes once it becomes legal.
- R10: A byte written to an address is returned by a later read of that address.
- R11: `sram_dq_oe` is high only during write accesses and never while `sram_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rd_stb_setup | input | PW | Read strobe setup ticks |
| cfg_rd_stb_pulse | input | PW | Read strobe low ticks |
| cfg_rd_cs_setup | input | PW | Read chip-select setup ticks |
| cfg_rd_cs_pulse | input | PW | Read chip-select low ticks |
| cfg_rd_cycle | input | 9 | Encoded read length |
| cfg_wr_stb_setup | input | PW | Write strobe setup ticks |
| cfg_wr_stb_pulse | input | PW | Write strobe low ticks |
| cfg_wr_cs_setup | input | PW | Write chip-select setup ticks |
| cfg_wr_cs_pulse | input | PW | Write chip-select low ticks |
| cfg_wr_cycle | input | 9 | Encoded write length |
| cfg_float | input | FW | Idle ticks required after a read |
| cfg_rd_by_strobe | input | 1 | 1: read strobe ends the read, 0: chip select |
| cfg_wr_by_strobe | input | 1 | 1: write strobe ends the write, 0: chip select |
| cfg_err | output | 1 | Illegal timing setting, accesses blocked |
| host_valid | input | 1 | Request present |
| host_ready | output | 1 | One-cycle completion, request consumed |
| host_we | input | 1 | 1 write, 0 read |
| host_addr | input | AW | Request address |
| host_wdata | input | DW | Write byte |
| host_rdata | output | DW | Read byte, valid with ready |
| sram_addr | output | AW | SRAM address |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Read strobe, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_dq_o | output | DW | Data driven to SRAM |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_dq_i | input | DW | Data returned by SRAM |

## Verification
Two events can land in the same cycle: read-data capture and the end of the access counter. This happens when the controlling read line is low through the last tick of the access, as with a 6-tick pulse inside a 6-tick read. The bench provokes it with a memory model that drives data only while both chip select and read strobe are low. It then checks that the byte shown with ready is the stored one, not the idle value 0x00. A second coincidence, a write request arriving while the post-read float count is still running, is judged by measuring the idle gap before the bus is driven.

// File: rtl/sram_tmg_pkg.sv
package sram_tmg_pkg;
  localparam int CYC_FIELD_W = 9;
  localparam int CNT_W = 10;

  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_DONE} acc_state_e;

  function automatic logic [CNT_W-1:0] decode_len(input logic [CYC_FIELD_W-1:0] f);
    return {f[8:7], 1'b0, f[6:0]};
  endfunction
endpackage

// File: rtl/sram_cfg_check.sv
module sram_cfg_check
  import sram_tmg_pkg::*;
#(
  parameter int PW = 6
) (
  input  logic [PW-1:0]          rd_stb_setup,
  input  logic [PW-1:0]          rd_stb_pulse,
  input  logic [PW-1:0]          rd_cs_setup,
  input  logic [PW-1:0]          rd_cs_pulse,
  input  logic [CYC_FIELD_W-1:0] rd_cycle,
  input  logic [PW-1:0]          wr_stb_setup,
  input  logic [PW-1:0]          wr_stb_pulse,
  input  logic [PW-1:0]          wr_cs_setup,
  input  logic [PW-1:0]          wr_cs_pulse,
  input  logic [CYC_FIELD_W-1:0] wr_cycle,
  input  logic                   rd_by_strobe,
  input  logic                   wr_by_strobe,
  output logic [CNT_W-1:0]       rd_len,
  output logic [CNT_W-1:0]       wr_len,
  output logic [CNT_W-1:0]       rd_ctrl_end,
  output logic                   bad
);
  localparam int PAD = CNT_W - PW;

  logic [PW-1:0]    setups [4];
  logic [PW-1:0]    pulses [4];
  logic [CNT_W-1:0] ends   [4];
  logic [3:0]       zero_pulse;

  assign setups[0] = rd_stb_setup;  assign pulses[0] = rd_stb_pulse;
  assign setups[1] = rd_cs_setup;   assign pulses[1] = rd_cs_pulse;
  assign setups[2] = wr_stb_setup;  assign pulses[2] = wr_stb_pulse;
  assign setups[3] = wr_cs_setup;   assign pulses[3] = wr_cs_pulse;

  for (genvar i = 0; i < 4; i++) begin : g_line
    assign ends[i]       = {{PAD{1'b0}}, setups[i]} + {{PAD{1'b0}}, pulses[i]};
    assign zero_pulse[i] = (pulses[i] == '0);
  end

  logic [CNT_W-1:0] wr_ctrl_end;

  always_comb begin
    rd_len      = decode_len(rd_cycle);
    wr_len      = decode_len(wr_cycle);
    rd_ctrl_end = rd_by_strobe ? ends[0] : ends[1];
    wr_ctrl_end = wr_by_strobe ? ends[2] : ends[3];
    bad = (|zero_pulse)
        | (ends[0] > rd_len) | (ends[1] > rd_len)
        | (ends[2] > wr_len) | (ends[3] > wr_len)
        | (wr_ctrl_end >= wr_len);
  end
endmodule

// File: rtl/sram_line_window.sv
module sram_line_window
  import sram_tmg_pkg::*;
#(
  parameter int PW = 6
) (
  input  logic [CNT_W-1:0] tick,
  input  logic [PW-1:0]    setup,
  input  logic [PW-1:0]    pulse,
  output logic             active
);
  localparam int PAD = CNT_W - PW;
  logic [CNT_W-1:0] lo, hi;
  assign lo     = {{PAD{1'b0}}, setup};
  assign hi     = lo + {{PAD{1'b0}}, pulse};
  assign active = (tick >= lo) && (tick < hi);
endmodule

// File: rtl/sram_float_timer.sv
module sram_float_timer #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] count,
  output logic          busy
);
  logic [FW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            remain <= '0;
    else if (load)         remain <= count;
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/sram_timing_ctrl.sv
module sram_timing_ctrl
  import sram_tmg_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 8,
  parameter int PW = 6,
  parameter int FW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PW-1:0]          cfg_rd_stb_setup,
  input  logic [PW-1:0]          cfg_rd_stb_pulse,
  input  logic [PW-1:0]          cfg_rd_cs_setup,
  input  logic [PW-1:0]          cfg_rd_cs_pulse,
  input  logic [CYC_FIELD_W-1:0] cfg_rd_cycle,
  input  logic [PW-1:0]          cfg_wr_stb_setup,
  input  logic [PW-1:0]          cfg_wr_stb_pulse,
  input  logic [PW-1:0]          cfg_wr_cs_setup,
  input  logic [PW-1:0]          cfg_wr_cs_pulse,
  input  logic [CYC_FIELD_W-1:0] cfg_wr_cycle,
  input  logic [FW-1:0]          cfg_float,
  input  logic                   cfg_rd_by_strobe,
  input  logic                   cfg_wr_by_strobe,
  output logic                   cfg_err,
  input  logic                   host_valid,
  output logic                   host_ready,
  input  logic                   host_we,
  input  logic [AW-1:0]          host_addr,
  input  logic [DW-1:0]          host_wdata,
  output logic [DW-1:0]          host_rdata,
  output logic [AW-1:0]          sram_addr,
  output logic                   sram_cs_n,
  output logic                   sram_oe_n,
  output logic                   sram_we_n,
  output logic [DW-1:0]          sram_dq_o,
  output logic                   sram_dq_oe,
  input  logic [DW-1:0]          sram_dq_i
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  acc_state_e       state, state_n;
  logic [CNT_W-1:0] tick, tick_n;
  logic             op_wr, op_wr_n;
  logic             start;
  logic [CNT_W-1:0] rd_len, wr_len, rd_ctrl_end, cur_len;
  logic             cfg_bad, float_busy, last_tick;

  sram_cfg_check #(.PW(PW)) u_check (
    .rd_stb_setup(cfg_rd_stb_setup), .rd_stb_pulse(cfg_rd_stb_pulse),
    .rd_cs_setup(cfg_rd_cs_setup),   .rd_cs_pulse(cfg_rd_cs_pulse),
    .rd_cycle(cfg_rd_cycle),
    .wr_stb_setup(cfg_wr_stb_setup), .wr_stb_pulse(cfg_wr_stb_pulse),
    .wr_cs_setup(cfg_wr_cs_setup),   .wr_cs_pulse(cfg_wr_cs_pulse),
    .wr_cycle(cfg_wr_cycle),
    .rd_by_strobe(cfg_rd_by_strobe), .wr_by_strobe(cfg_wr_by_strobe),
    .rd_len(rd_len), .wr_len(wr_len), .rd_ctrl_end(rd_ctrl_end), .bad(cfg_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= cfg_bad;
  end

  assign cur_len   = op_wr ? wr_len : rd_len;
  assign last_tick = (state == ST_ACC) && (tick == cur_len - ONE);

  // Next-state logic: outputs are registered from the next tick value
  always_comb begin
    state_n = state;
    tick_n  = tick;
    op_wr_n = op_wr;
    start   = 1'b0;
    unique case (state)
      ST_IDLE: if (host_valid && !cfg_err && !(host_we && float_busy)) begin
        state_n = ST_ACC;
        tick_n  = '0;
        op_wr_n = host_we;
        start   = 1'b1;
      end
      ST_ACC: begin
        if (last_tick) state_n = ST_DONE;
        else           tick_n  = tick + ONE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // Line windows for the strobe (index 0) and chip select (index 1)
  logic [PW-1:0] win_setup [2];
  logic [PW-1:0] win_pulse [2];
  logic [1:0]    win_on;

  assign win_setup[0] = op_wr_n ? cfg_wr_stb_setup : cfg_rd_stb_setup;
  assign win_pulse[0] = op_wr_n ? cfg_wr_stb_pulse : cfg_rd_stb_pulse;
  assign win_setup[1] = op_wr_n ? cfg_wr_cs_setup  : cfg_rd_cs_setup;
  assign win_pulse[1] = op_wr_n ? cfg_wr_cs_pulse  : cfg_rd_cs_pulse;

  for (genvar w = 0; w < 2; w++) begin : g_win
    sram_line_window #(.PW(PW)) u_win (
      .tick(tick_n), .setup(win_setup[w]), .pulse(win_pulse[w]), .active(win_on[w])
    );
  end

  logic in_acc_n;
  assign in_acc_n = (state_n == ST_ACC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      tick       <= '0;
      op_wr      <= 1'b0;
      sram_cs_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_dq_oe <= 1'b0;
      sram_addr  <= '0;
      sram_dq_o  <= '0;
      host_ready <= 1'b0;
      host_rdata <= '0;
    end else begin
      state      <= state_n;
      tick       <= tick_n;
      op_wr      <= op_wr_n;
      sram_cs_n  <= !(in_acc_n && win_on[1]);
      sram_oe_n  <= !(in_acc_n && !op_wr_n && win_on[0]);
      sram_we_n  <= !(in_acc_n && op_wr_n && win_on[0]);
      sram_dq_oe <= in_acc_n && op_wr_n;
      host_ready <= (state_n == ST_DONE);
      if (start) begin
        sram_addr <= host_addr;
        sram_dq_o <= host_wdata;
      end
      if (state == ST_ACC && !op_wr && tick == rd_ctrl_end - ONE)
        host_rdata <= sram_dq_i;
    end
  end

  sram_float_timer #(.FW(FW)) u_float (
    .clk(clk), .rst_n(rst_n),
    .load(last_tick && !op_wr), .count(cfg_float), .busy(float_busy)
  );

  // Checker state: idle ticks since the last read-side line activity
  localparam logic [FW:0] GAP_MAX = '1;
  logic [FW:0] gap_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      gap_cnt <= GAP_MAX;
    else if ((!sram_cs_n || !sram_oe_n) && !sram_dq_oe) gap_cnt <= '0;
    else if (gap_cnt != GAP_MAX)                     gap_cnt <= gap_cnt + 1'b1;
  end

  assert_float_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (gap_cnt >= {1'b0, cfg_float}))
    else $error("write drove bus too soon after read");

  assert_ready_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready)
    else $error("ready longer than one cycle");

  assert_no_start_on_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && state == ST_IDLE) |=> (state != ST_ACC))
    else $error("access started with illegal setting");

  assert_bus_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n)
    else $error("bus driven while read strobe low");

  assert_we_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sram_we_n) && cfg_wr_by_strobe && !cfg_err) |-> sram_dq_oe)
    else $error("data released with write strobe edge");

  assert_cs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sram_cs_n) && $past(sram_dq_oe) && !cfg_wr_by_strobe && !cfg_err) |-> sram_dq_oe)
    else $error("data released with chip select edge");

  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr))
    else $error("address moved during chip select");
endmodule

// File: tb/test_sram_timing_ctrl.sv
module test_sram_timing_ctrl;
  localparam int AW = 8, DW = 8, PW = 6, FW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [PW-1:0] cfg_rd_stb_setup, cfg_rd_stb_pulse, cfg_rd_cs_setup, cfg_rd_cs_pulse;
  logic [PW-1:0] cfg_wr_stb_setup, cfg_wr_stb_pulse, cfg_wr_cs_setup, cfg_wr_cs_pulse;
  logic [8:0]    cfg_rd_cycle, cfg_wr_cycle;
  logic [FW-1:0] cfg_float;
  logic          cfg_rd_by_strobe, cfg_wr_by_strobe, cfg_err;
  logic          host_valid = 1'b0, host_ready, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0, sram_addr;
  logic [DW-1:0] host_wdata = '0, host_rdata, sram_dq_o, sram_dq_i;
  logic          sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe;

  sram_timing_ctrl #(.AW(AW), .DW(DW), .PW(PW), .FW(FW)) i_sram_timing_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_rd_stb_setup(cfg_rd_stb_setup), .cfg_rd_stb_pulse(cfg_rd_stb_pulse),
    .cfg_rd_cs_setup(cfg_rd_cs_setup), .cfg_rd_cs_pulse(cfg_rd_cs_pulse),
    .cfg_rd_cycle(cfg_rd_cycle),
    .cfg_wr_stb_setup(cfg_wr_stb_setup), .cfg_wr_stb_pulse(cfg_wr_stb_pulse),
    .cfg_wr_cs_setup(cfg_wr_cs_setup), .cfg_wr_cs_pulse(cfg_wr_cs_pulse),
    .cfg_wr_cycle(cfg_wr_cycle), .cfg_float(cfg_float),
    .cfg_rd_by_strobe(cfg_rd_by_strobe), .cfg_wr_by_strobe(cfg_wr_by_strobe),
    .cfg_err(cfg_err),
    .host_valid(host_valid), .host_ready(host_ready), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
    .sram_dq_i(sram_dq_i)
  );

  int checks = 0, errors = 0;

  // SRAM model: drives data only while selected and read-enabled
  logic [7:0] mem [256];
  assign sram_dq_i = (!sram_cs_n && !sram_oe_n) ? mem[sram_addr] : 8'h00;

  logic act_q = 1'b0;
  longint gcyc = 0, last_rd_act = -100, last_gap = -1;
  logic dq_oe_q = 1'b0;
  always @(negedge clk) begin
    gcyc = gcyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h11;
      act_q = 1'b0;
    end else begin
      if (act_q && !(!sram_cs_n && !sram_we_n)) begin
        checks++;
        if (!sram_dq_oe) begin
          errors++;
          $display("FAIL R7 data not held at latch edge: dq_oe=%0d exp=1", sram_dq_oe);
        end
        mem[sram_addr] = sram_dq_o;
      end
      act_q = !sram_cs_n && !sram_we_n;
      if ((!sram_cs_n || !sram_oe_n) && !sram_dq_oe) last_rd_act = gcyc;
      if (sram_dq_oe && !dq_oe_q) last_gap = gcyc - last_rd_act - 1;
      dq_oe_q = sram_dq_oe;
    end
  end

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic chk_ge(input string tag, input longint got, input longint lim);
    checks++;
    if (got < lim) begin
      errors++;
      $display("FAIL %s got=%0d exp>=%0d", tag, got, lim);
    end
  endtask

  int m_cs_first, m_cs_cnt, m_oe_first, m_oe_cnt, m_we_first, m_we_cnt;
  int m_dq_first, m_dq_cnt, m_rdy;

  task automatic run_acc(input logic we, input logic [7:0] a, input logic [7:0] d,
                         output logic [7:0] rd);
    int k = 0;
    bit got = 0;
    rd = 8'h00;
    host_we = we; host_addr = a; host_wdata = d; host_valid = 1'b1;
    m_cs_first = -1; m_oe_first = -1; m_we_first = -1; m_dq_first = -1;
    m_cs_cnt = 0; m_oe_cnt = 0; m_we_cnt = 0; m_dq_cnt = 0; m_rdy = -1;
    while (!got && k < 2000) begin
      @(negedge clk);
      if (!sram_cs_n) begin if (m_cs_first < 0) m_cs_first = k; m_cs_cnt++; end
      if (!sram_oe_n) begin if (m_oe_first < 0) m_oe_first = k; m_oe_cnt++; end
      if (!sram_we_n) begin if (m_we_first < 0) m_we_first = k; m_we_cnt++; end
      if (sram_dq_oe) begin if (m_dq_first < 0) m_dq_first = k; m_dq_cnt++; end
      if (host_ready) begin got = 1; m_rdy = k; rd = host_rdata; end
      k++;
    end
    if (!got) begin
      checks++; errors++;
      $display("FAIL R9 no ready: got=0 exp=1");
    end
    @(negedge clk);
    chk("R9 ready is single cycle", host_ready, 0);
    host_valid = 1'b0;
  endtask

  task automatic set_defaults();
    cfg_rd_stb_setup = 0; cfg_rd_stb_pulse = 6; cfg_rd_cs_setup = 0; cfg_rd_cs_pulse = 6;
    cfg_rd_cycle = 9'd6;
    cfg_wr_stb_setup = 0; cfg_wr_stb_pulse = 5; cfg_wr_cs_setup = 0; cfg_wr_cs_pulse = 5;
    cfg_wr_cycle = 9'd6;
    cfg_float = 3; cfg_rd_by_strobe = 1; cfg_wr_by_strobe = 1;
  endtask

  // {write, address, data-or-expected}
  localparam logic [16:0] VEC [12] = '{
    {1'b1, 8'h00, 8'hA5}, {1'b1, 8'h01, 8'h3C}, {1'b1, 8'hFE, 8'h00}, {1'b1, 8'hFF, 8'hFF},
    {1'b0, 8'h00, 8'hA5}, {1'b0, 8'h01, 8'h3C}, {1'b0, 8'hFE, 8'h00}, {1'b0, 8'hFF, 8'hFF},
    {1'b1, 8'h01, 8'hC3}, {1'b0, 8'h01, 8'hC3}, {1'b1, 8'h80, 8'h69}, {1'b0, 8'h80, 8'h69}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: got=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    set_defaults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cs_n", sram_cs_n, 1);
    chk("R1 oe_n", sram_oe_n, 1);
    chk("R1 we_n", sram_we_n, 1);
    chk("R1 dq_oe", sram_dq_oe, 0);
    chk("R1 ready", host_ready, 0);
    chk("R1 cfg_err", cfg_err, 0);

    // R10 table walk (pulse equals length on reads: capture meets access end)
    for (int i = 0; i < 12; i++) begin
      run_acc(VEC[i][16], VEC[i][15:8], VEC[i][7:0], rd);
      if (!VEC[i][16]) chk($sformatf("R10 read vector %0d", i), rd, VEC[i][7:0]);
      else begin
        chk("R5 zero setup: we with bus drive", m_we_first, m_dq_first);
        chk("R11 no read strobe in write", m_oe_cnt, 0);
      end
    end

    // R2 / R4 decoded length and windows on a write
    cfg_wr_stb_setup = 2; cfg_wr_stb_pulse = 5; cfg_wr_cs_setup = 0; cfg_wr_cs_pulse = 10;
    cfg_wr_cycle = 9'b1_0000100;
    repeat (2) @(negedge clk);
    chk("R7 legal long write", cfg_err, 0);
    run_acc(1'b1, 8'h40, 8'h5E, rd);
    chk("R2 write length 260", m_dq_cnt, 260);
    chk("R4 we offset", m_we_first - m_dq_first, 2);
    chk("R4 we width", m_we_cnt, 5);
    chk("R4 cs width write", m_cs_cnt, 10);

    // R2 / R4 read windows and length
    cfg_rd_stb_setup = 3; cfg_rd_stb_pulse = 4; cfg_rd_cs_setup = 1; cfg_rd_cs_pulse = 8;
    cfg_rd_cycle = 9'd10;
    repeat (2) @(negedge clk);
    run_acc(1'b0, 8'h40, 8'h00, rd);
    chk("R10 read back long write", rd, 8'h5E);
    chk("R4 oe width", m_oe_cnt, 4);
    chk("R4 cs width read", m_cs_cnt, 8);
    chk("R4 oe after cs", m_oe_first - m_cs_first, 2);
    chk("R2 read length from cs", m_rdy - m_cs_first, 9);
    chk("R11 no bus drive in read", m_dq_cnt, 0);

    // R6 capture point by mode
    set_defaults();
    cfg_rd_stb_setup = 1; cfg_rd_stb_pulse = 3;
    repeat (2) @(negedge clk);
    run_acc(1'b0, 8'h80, 8'h00, rd);
    chk("R6 strobe-controlled capture", rd, 8'h69);
    cfg_rd_by_strobe = 0;
    repeat (2) @(negedge clk);
    run_acc(1'b0, 8'h80, 8'h00, rd);
    chk("R6 cs-controlled capture after strobe ends", rd, 8'h00);
    set_defaults();
    cfg_rd_by_strobe = 0;
    repeat (2) @(negedge clk);
    run_acc(1'b0, 8'h80, 8'h00, rd);
    chk("R6 cs-controlled capture aligned", rd, 8'h69);

    // R7 configuration legality by write mode
    set_defaults();
    cfg_wr_cycle = 9'd5;
    repeat (2) @(negedge clk);
    chk("R7 write length not above strobe end", cfg_err, 1);
    cfg_wr_cycle = 9'd6; cfg_wr_cs_pulse = 6; cfg_wr_by_strobe = 0;
    repeat (2) @(negedge clk);
    chk("R7 cs-controlled cs end at length", cfg_err, 1);
    cfg_wr_by_strobe = 1;
    repeat (2) @(negedge clk);
    chk("R7 strobe-controlled with cs to end", cfg_err, 0);
    set_defaults();
    cfg_rd_cs_pulse = 7;
    repeat (2) @(negedge clk);
    chk("R7 read cs beyond length", cfg_err, 1);
    set_defaults();
    cfg_wr_by_strobe = 0; cfg_wr_cs_pulse = 4;
    repeat (2) @(negedge clk);
    chk("R7 cs-controlled legal", cfg_err, 0);
    run_acc(1'b1, 8'h22, 8'h96, rd);
    run_acc(1'b0, 8'h22, 8'h00, rd);
    chk("R10 cs-controlled write data", rd, 8'h96);

    // R8 float gap with a write queued behind a read
    set_defaults();
    cfg_float = 9;
    repeat (2) @(negedge clk);
    run_acc(1'b0, 8'h22, 8'h00, rd);
    run_acc(1'b1, 8'h23, 8'h4B, rd);
    chk_ge("R8 idle ticks before drive", last_gap, 9);
    cfg_float = 0;
    repeat (2) @(negedge clk);
    run_acc(1'b0, 8'h23, 8'h00, rd);
    chk("R10 read after float", rd, 8'h4B);

    // R3 zero pulse blocks; R9 held request completes later
    set_defaults();
    cfg_wr_cs_pulse = 0;
    repeat (2) @(negedge clk);
    chk("R3 zero pulse flagged", cfg_err, 1);
    host_we = 1'b1; host_addr = 8'h33; host_wdata = 8'hE7; host_valid = 1'b1;
    begin
      int cs_low = 0, rdy = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (!sram_cs_n) cs_low++;
        if (host_ready) rdy++;
      end
      chk("R3 no chip select while blocked", cs_low, 0);
      chk("R3 no ready while blocked", rdy, 0);
    end
    cfg_wr_cs_pulse = 5;
    run_acc(1'b1, 8'h33, 8'hE7, rd);
    run_acc(1'b0, 8'h33, 8'h00, rd);
    chk("R9 held request written", rd, 8'hE7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule